// File: doc/BRIEF.md
# Addressable RGB LED Chain Serializer

This block drives one daisy-chain of single-wire addressable RGB LEDs from a 12 MHz clock. A producer hands over 24-bit colour words on a valid/ready handshake. The block serializes each word onto one output line. Every bit has a fixed period, and the bit value is carried by how long the line stays high at the start of that period.

A frame holds a configurable number of pixels. Once the final pixel has been shifted out, the line is held low for a long latch interval so that every LED in the chain takes up its new colour. A one-cycle frame-done pulse then marks the end of the frame. Words for one frame can follow each other with no idle time on the line. If the producer falls behind in the middle of a frame, the line waits low. A stall that lasts too long raises an underrun pulse.

Top module: `led_chain_tx`

## Requirements
- R1: While `rst` is high and after it is released, `dout`, `busy`, `frame_done` and `underrun` are low and `pix_ready` is high, with every counter cleared.
- R2: `pix_data[23:16]` holds green, `[15:8]` red and `[7:0]` blue. Bit 23 goes out first and bit 0 last, so the order is green, red, blue and each byte is sent most significant bit first.
- R3: Every bit lasts 16 clocks, made of four ticks of four clocks. A one is high for 12 clocks and then low for 4. A zero is high for 4 clocks and then low for 12. The first high clock appears two cycles after the accepting edge.
- R4: Within a frame, `pix_ready` is high for exactly one cycle per pixel except the last, on the final clock of that pixel's last bit. A word taken on that cycle starts with no gap, so rising edges stay 16 clocks apart.
- R5: `pix_count` is sampled when the first word of a frame is accepted. A value of 0 counts as 1, and changes made during the frame have no effect.
- R6: After the final bit of the frame, the line stays low for LATCH_CYCLES further clocks (default 1200, which is 100 us). `frame_done` then pulses high for one clock. The low run measured up to that pulse is LATCH_CYCLES plus the low part of the last bit.
- R7: `busy` is high from the cycle after the first accept until the latch ends: N×16×24 + LATCH_CYCLES cycles for a frame of N pixels with no stall. No word is accepted during the latch.
- R8: If no word is offered at a pixel boundary inside a frame, the line stays low and `pix_ready` stays high until a word arrives, and the frame then continues correctly. If the stall reaches STALL_LIMIT cycles (default 60, which is 5 us), `underrun` pulses high for exactly one cycle.
- R9: With no frame in progress, `dout` stays low.
- R10: A reset in the middle of a frame forces the line low and returns the block to idle. The next frame is serialized correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| pix_data | input | 24 | Colour word {green, red, blue} |
| pix_valid | input | 1 | Producer offers `pix_data` |
| pix_ready | output | 1 | Block takes the word on this edge when valid |
| pix_count | input | CNT_W | Pixels per frame, sampled at frame start |
| dout | output | 1 | Serial line to the LED chain |
| busy | output | 1 | Frame in progress, including the latch |
| frame_done | output | 1 | One-cycle pulse when the latch ends |
| underrun | output | 1 | One-cycle pulse when a mid-frame stall reaches the limit |

## Verification
The in-line assertions check, on every cycle, the properties that hold locally. The line is low whenever no bit is being sent. The ready strobe inside a pixel lasts one cycle, and no word is taken during the latch. Frame-done and underrun are single-cycle pulses, and the pixel index stays within the latched frame length. The remaining behaviour only shows over whole frames, so the bench's scenarios cover it. They check the serial bit order against the colour words, the exact high widths and the 16-clock spacing of rising edges. They also check the exact length of the low run before frame-done, the busy duration, the treatment of a zero pixel count and the handling of short and long stalls.

// File: rtl/led_chain_pkg.sv
package led_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_GAP   = 2'd2,
    ST_LATCH = 2'd3
  } lc_state_t;

  localparam int unsigned PIX_BITS = 24;

  // clocks that make up one serial bit
  function automatic int unsigned lc_clks_per_bit(input int unsigned clk_per_tick,
                                                  input int unsigned ticks_per_bit);
    return clk_per_tick * ticks_per_bit;
  endfunction

  // number of high ticks for a given bit value
  function automatic int unsigned lc_hi_ticks(input logic bval,
                                              input int unsigned one_ticks,
                                              input int unsigned zero_ticks);
    return bval ? one_ticks : zero_ticks;
  endfunction

  // width needed to count 0..n-1 (at least 1)
  function automatic int unsigned lc_cw(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lct_bit_timer.sv
module lct_bit_timer
  import led_chain_pkg::*;
#(
  parameter int unsigned CLK_PER_TICK  = 4,
  parameter int unsigned TICKS_PER_BIT = 4,
  localparam int unsigned CLKS = lc_clks_per_bit(CLK_PER_TICK, TICKS_PER_BIT),
  localparam int unsigned CW   = lc_cw(CLKS),
  localparam int unsigned TW   = lc_cw(TICKS_PER_BIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          bit_last,
  output logic [TW-1:0] tick_idx
);

  localparam logic [CW-1:0] CYC_LAST = CW'(CLKS - 1);

  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc <= '0;
    end else if (cyc == CYC_LAST) begin
      cyc <= '0;
    end else begin
      cyc <= cyc + CW'(1);
    end
  end

  assign bit_last = run && (cyc == CYC_LAST);
  assign tick_idx = TW'(32'(cyc) / 32'(CLK_PER_TICK));

  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (rst)
    cyc <= CYC_LAST); // R3

  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !bit_last) |=> (cyc != '0)); // R3

endmodule

// File: rtl/lct_shift24.sv
module lct_shift24
  import led_chain_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [PIX_BITS-1:0] word,
  input  logic                shift,
  output logic                cur_bit,
  output logic                last_bit
);

  localparam int unsigned BW = lc_cw(PIX_BITS);
  localparam logic [BW-1:0] BIDX_LAST = BW'(PIX_BITS - 1);

  logic [PIX_BITS-1:0] sreg;
  logic [BW-1:0]       bidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      bidx <= '0;
    end else if (load) begin
      sreg <= word;
      bidx <= '0;
    end else if (shift) begin
      sreg <= {sreg[PIX_BITS-2:0], 1'b0};
      bidx <= (bidx == BIDX_LAST) ? '0 : bidx + BW'(1);
    end
  end

  // the word is sent from its top bit down
  assign cur_bit  = sreg[PIX_BITS-1];
  assign last_bit = (bidx == BIDX_LAST);

  AST_BIDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    bidx <= BIDX_LAST); // R2

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load |=> (bidx == '0)); // R2

endmodule

// File: rtl/lct_frame_ctrl.sv
module lct_frame_ctrl
  import led_chain_pkg::*;
#(
  parameter int unsigned CNT_W        = 10,
  parameter int unsigned LATCH_CYCLES = 1200,
  parameter int unsigned STALL_LIMIT  = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_valid,
  input  logic [CNT_W-1:0] pix_count,
  input  logic             pix_end,
  output logic             pix_ready,
  output logic             accept,
  output lc_state_t        state,
  output logic             frame_done,
  output logic             underrun
);

  localparam int unsigned LW = lc_cw(LATCH_CYCLES + 1);
  localparam int unsigned SW = lc_cw(STALL_LIMIT + 1);
  localparam logic [LW-1:0] LAT_LAST   = LW'(LATCH_CYCLES - 1);
  localparam logic [SW-1:0] STALL_LAST = SW'(STALL_LIMIT - 1);
  localparam logic [SW-1:0] STALL_SAT  = SW'(STALL_LIMIT);

  logic [CNT_W-1:0] frame_len;
  logic [CNT_W-1:0] pix_idx;
  logic [LW-1:0]    lat_cnt;
  logic [SW-1:0]    stall_cnt;
  logic             frame_last;
  logic             latch_end;
  logic             stall_hit;

  assign frame_last = (pix_idx == frame_len - CNT_W'(1));
  assign latch_end  = (state == ST_LATCH) && (lat_cnt == LAT_LAST);
  assign stall_hit  = (state == ST_GAP) && (stall_cnt == STALL_LAST) && !pix_valid;

  always_comb begin
    unique case (state)
      ST_IDLE:  pix_ready = 1'b1;
      ST_GAP:   pix_ready = 1'b1;
      ST_SEND:  pix_ready = pix_end && !frame_last;
      default:  pix_ready = 1'b0;
    endcase
  end

  assign accept = pix_ready && pix_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      frame_len  <= CNT_W'(1);
      pix_idx    <= '0;
      lat_cnt    <= '0;
      stall_cnt  <= '0;
      frame_done <= 1'b0;
      underrun   <= 1'b0;
    end else begin
      frame_done <= latch_end;
      underrun   <= stall_hit;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_SEND;
            pix_idx   <= '0;
            frame_len <= (pix_count == '0) ? CNT_W'(1) : pix_count;
          end
        end
        ST_SEND: begin
          if (pix_end) begin
            if (frame_last) begin
              state   <= ST_LATCH;
              lat_cnt <= '0;
            end else begin
              pix_idx <= pix_idx + CNT_W'(1);
              if (!accept) begin
                state     <= ST_GAP;
                stall_cnt <= '0;
              end
            end
          end
        end
        ST_GAP: begin
          if (accept) begin
            state <= ST_SEND;
          end else if (stall_cnt != STALL_SAT) begin
            stall_cnt <= stall_cnt + SW'(1);
          end
        end
        default: begin
          if (lat_cnt == LAT_LAST) begin
            state <= ST_IDLE;
          end else begin
            lat_cnt <= lat_cnt + LW'(1);
          end
        end
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && accept) |=> !pix_ready); // R4

  AST_NO_TAKE_LATCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH) |-> !pix_ready); // R7

  AST_PIX_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (pix_idx < frame_len)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (state == ST_IDLE)); // R6

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun); // R8

endmodule

// File: rtl/led_chain_tx.sv
module led_chain_tx
  import led_chain_pkg::*;
#(
  parameter int unsigned CNT_W         = 10,
  parameter int unsigned CLK_PER_TICK  = 4,
  parameter int unsigned TICKS_PER_BIT = 4,
  parameter int unsigned ONE_HI_TICKS  = 3,
  parameter int unsigned ZERO_HI_TICKS = 1,
  parameter int unsigned LATCH_CYCLES  = 1200,
  parameter int unsigned STALL_LIMIT   = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [23:0]      pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [CNT_W-1:0] pix_count,
  output logic             dout,
  output logic             busy,
  output logic             frame_done,
  output logic             underrun
);

  localparam int unsigned TW = lc_cw(TICKS_PER_BIT);

  lc_state_t     state_q;
  logic          run;
  logic          bit_last;
  logic [TW-1:0] tick_idx;
  logic          cur_bit;
  logic          last_bit;
  logic          pix_end;
  logic          accept;
  logic          dout_next;

  assign run     = (state_q == ST_SEND);
  assign pix_end = bit_last && last_bit;

  lct_bit_timer #(
    .CLK_PER_TICK (CLK_PER_TICK),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .bit_last(bit_last),
    .tick_idx(tick_idx)
  );

  lct_shift24 u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .word    (pix_data),
    .shift   (bit_last),
    .cur_bit (cur_bit),
    .last_bit(last_bit)
  );

  lct_frame_ctrl #(
    .CNT_W       (CNT_W),
    .LATCH_CYCLES(LATCH_CYCLES),
    .STALL_LIMIT (STALL_LIMIT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .pix_count (pix_count),
    .pix_end   (pix_end),
    .pix_ready (pix_ready),
    .accept    (accept),
    .state     (state_q),
    .frame_done(frame_done),
    .underrun  (underrun)
  );

  // line is high for the leading ticks of the bit, count set by its value
  assign dout_next = run &&
    (32'(tick_idx) < lc_hi_ticks(cur_bit, ONE_HI_TICKS, ZERO_HI_TICKS));

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
    end else begin
      dout <= dout_next;
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_OUT_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_SEND) |=> !dout); // R9

  AST_FIRST_HIGH: assert property (@(posedge clk) disable iff (rst)
    (accept && state_q == ST_IDLE) |=> ##1 dout); // R3

  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy); // R7

endmodule

// File: tb/sim_led_chain_tx.sv
`timescale 1ns/1ps
module sim_led_chain_tx;

  localparam int CNT_W = 4;
  localparam int LAT   = 40;
  localparam int STALL = 20;
  localparam int BITCL = 16;
  localparam int PIXCL = BITCL * 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [23:0]      pix_data = '0;
  logic             pix_valid = 1'b0;
  logic             pix_ready;
  logic [CNT_W-1:0] pix_count = '0;
  logic             dout;
  logic             busy;
  logic             frame_done;
  logic             underrun;

  always #2.5 clk = ~clk;

  led_chain_tx #(
    .CNT_W(CNT_W), .CLK_PER_TICK(4), .TICKS_PER_BIT(4),
    .ONE_HI_TICKS(3), .ZERO_HI_TICKS(1),
    .LATCH_CYCLES(LAT), .STALL_LIMIT(STALL)
  ) u0 (
    .clk(clk), .rst(rst), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_count(pix_count), .dout(dout),
    .busy(busy), .frame_done(frame_done), .underrun(underrun)
  );

  int total = 0;
  int bad   = 0;

  // line monitor, samples on the falling clock edge
  bit dec_q[$];
  int hr, lr, since_rise, bad_gap, bad_width, done_cnt, last_low;
  int busy_cyc, rdy_busy, urun_cnt;
  bit prev_d, have_rise;

  task automatic clear_mon();
    dec_q.delete();
    hr = 0; lr = 0; since_rise = 0; bad_gap = 0; bad_width = 0;
    done_cnt = 0; last_low = 0; busy_cyc = 0; rdy_busy = 0; urun_cnt = 0;
    prev_d = 1'b0; have_rise = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      since_rise++;
      if (dout && !prev_d) begin
        if (have_rise && since_rise != BITCL) bad_gap++;
        have_rise = 1'b1;
        since_rise = 0;
      end
      if (dout) begin
        hr++;
        lr = 0;
      end else begin
        if (prev_d) begin
          if (hr == 12) dec_q.push_back(1'b1);
          else if (hr == 4) dec_q.push_back(1'b0);
          else bad_width++;
        end
        hr = 0;
        lr++;
      end
      if (frame_done) begin
        done_cnt++;
        last_low = lr;
        have_rise = 1'b0;
      end
      if (busy) busy_cyc++;
      if (busy && pix_ready) rdy_busy++;
      if (underrun) urun_cnt++;
      prev_d = dout;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int p, input int i);
    case (p)
      0:       return 24'h000000;
      1:       return 24'hFFFFFF;
      2:       return 24'hA53C96 ^ {3{8'(i)}};
      default: return {8'(8'h11 * (i + 1)), 8'(8'h80 >> i), 8'(~i)};
    endcase
  endfunction

  task automatic feed(input int n, input int p, input int stall_at, input int stall_len);
    for (int i = 0; i < n; i++) begin
      if (i == stall_at) begin
        while (!pix_ready) @(negedge clk);
        @(posedge clk); #1;
        repeat (stall_len) @(negedge clk);
      end
      pix_data  = pat(p, i);
      pix_valid = 1'b1;
      while (!pix_ready) @(negedge clk);
      @(posedge clk); #1;
      pix_valid = 1'b0;
    end
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(posedge clk);
    #1;
  endtask

  // compares the decoded line against the words, top bit of each word first
  task automatic cmp_bits(input int n, input int p, input string req);
    int miss = 0;
    check(dec_q.size() == 24 * n, {req, " bit count"}, dec_q.size(), 24 * n);
    if (dec_q.size() == 24 * n) begin
      for (int i = 0; i < n; i++) begin
        logic [23:0] w = pat(p, i);
        for (int b = 23; b >= 0; b--) begin
          if (dec_q[i * 24 + (23 - b)] != w[b]) miss++;
        end
      end
    end
    check(miss == 0, {req, " bit order"}, miss, 0);
  endtask

  function automatic int exp_low(input logic [23:0] last_word);
    return LAT + BITCL - (last_word[0] ? 12 : 4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    // R1 reset values
    check(dout == 1'b0, "R1 dout", dout, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(frame_done == 1'b0, "R1 frame_done", frame_done, 0);
    check(pix_ready == 1'b1, "R1 pix_ready", pix_ready, 1);
    check(underrun == 1'b0, "R1 underrun", underrun, 0);
    @(posedge clk); #1;
    rst = 1'b0;

    // R9 idle line low
    begin
      int highs = 0;
      repeat (50) begin @(negedge clk); if (dout) highs++; end
      check(highs == 0, "R9 idle low", highs, 0);
    end

    // sweep: pixel counts 1..4 times four colour patterns, back to back
    for (int n = 1; n <= 4; n++) begin
      for (int p = 0; p < 4; p++) begin
        @(posedge clk); #1;
        clear_mon();
        pix_count = CNT_W'(n);
        feed(n, p, -1, 0);
        wait_done(1);
        cmp_bits(n, p, "R2/R3");
        check(bad_width == 0, "R3 high width", bad_width, 0);
        check(bad_gap == 0, "R4 bit spacing", bad_gap, 0);
        check(rdy_busy == n - 1, "R4 ready pulses", rdy_busy, n - 1);
        check(last_low == exp_low(pat(p, n - 1)), "R6 latch low", last_low, exp_low(pat(p, n - 1)));
        check(busy_cyc == n * PIXCL + LAT, "R7 busy length", busy_cyc, n * PIXCL + LAT);
        check(urun_cnt == 0, "R8 no underrun", urun_cnt, 0);
      end
    end

    // R6 frame_done pulse length: one sample only
    @(posedge clk); #1;
    clear_mon();
    pix_count = CNT_W'(1);
    feed(1, 3, -1, 0);
    wait_done(1);
    repeat (5) @(negedge clk);
    check(done_cnt == 1, "R6 single pulse", done_cnt, 1);

    // R5 zero count means one pixel
    @(posedge clk); #1;
    clear_mon();
    pix_count = '0;
    feed(1, 2, -1, 0);
    wait_done(1);
    cmp_bits(1, 2, "R5 zero count");

    // R5 count changed mid-frame is ignored
    @(posedge clk); #1;
    clear_mon();
    pix_count = CNT_W'(3);
    feed(1, 3, -1, 0);
    pix_count = CNT_W'(1);
    feed(2, 3, -1, 0);
    wait_done(1);
    check(dec_q.size() == 72, "R5 count latched", dec_q.size(), 72);

    // R7 no accept during the latch
    @(posedge clk); #1;
    clear_mon();
    pix_count = CNT_W'(2);
    feed(2, 1, -1, 0);
    pix_count = CNT_W'(1);
    pix_data  = 24'h0F0F0F;
    pix_valid = 1'b1;
    while (!pix_ready) @(negedge clk);
    @(posedge clk); #1;
    pix_valid = 1'b0;
    check(done_cnt == 1, "R7 accept after latch", done_cnt, 1);
    wait_done(2);

    // R8 short stall: no underrun, data intact
    @(posedge clk); #1;
    clear_mon();
    pix_count = CNT_W'(3);
    feed(3, 3, 1, 5);
    wait_done(1);
    cmp_bits(3, 3, "R8 short stall");
    check(urun_cnt == 0, "R8 short stall flag", urun_cnt, 0);
    check(bad_gap == 1, "R8 stall gap", bad_gap, 1);

    // R8 long stall: one underrun pulse, data intact
    @(posedge clk); #1;
    clear_mon();
    pix_count = CNT_W'(3);
    feed(3, 2, 2, 2 * STALL);
    wait_done(1);
    cmp_bits(3, 2, "R8 long stall");
    check(urun_cnt == 1, "R8 long stall flag", urun_cnt, 1);
    check(bad_width == 0, "R8 stall width", bad_width, 0);

    // R10 reset in the middle of a frame
    @(posedge clk); #1;
    clear_mon();
    pix_count = CNT_W'(3);
    feed(1, 1, -1, 0);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(dout == 1'b0, "R10 dout after reset", dout, 0);
    check(busy == 1'b0, "R10 busy after reset", busy, 0);
    check(pix_ready == 1'b1, "R10 ready after reset", pix_ready, 1);
    @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;
    clear_mon();
    pix_count = CNT_W'(2);
    feed(2, 2, -1, 0);
    wait_done(1);
    cmp_bits(2, 2, "R10 recovery");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule